// File: doc/BRIEF.md
# IQ Phase Imbalance Corrector

This block sits in front of a pair of DACs and shifts the angle between an in-phase (I) and a quadrature (Q) sample stream. A quadrature modulator further down the chain can have a phase error. That error leaves an image sideband in the output. Moving the I/Q angle away from a right angle by a matching amount cancels most of that image.

The shift is a small-angle rotation that touches only the Q path. Each output Q is Q plus a scaled copy of I, with the scale set by a signed 10-bit correction word. One LSB of that word is 1/2048 radian, so the usable angle between the channels runs from about 75.7 to 104.3 degrees. I is only delayed, so that it stays aligned with Q.

Software loads the word through two byte-wide configuration strobes. A new word takes effect only once both halves have arrived.

Top module: `iq_phase_corrector`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid`, `out_i` and `out_q` are zero, and the active correction word is zero.
- R2: `out_valid` and `out_i` equal `in_valid` and `in_i` from exactly two clock edges earlier. The data pipeline advances on every cycle, whatever the state of the valid strobe.
- R3: With a correction word of zero, `out_q` equals `in_q` from two edges earlier, which keeps the nominal 90 degree relationship.
- R4: With correction word c (a signed two's-complement value from -512 to +511), `out_q` equals Q + floor(I*c / 2048). The divide is an arithmetic shift right by 11.
- R5: When that sum leaves the signed SAMPLE_W range, `out_q` clamps to -2^(SAMPLE_W-1) or 2^(SAMPLE_W-1)-1 and does not wrap.
- R6: A `cfg_lo_we` write stages `cfg_data[7:0]` as word bits [7:0]. A `cfg_hi_we` write stages `cfg_data[1:0]` as word bits [9:8]. `cfg_data[7:2]` has no effect on a high write.
- R7: The staged word becomes active on the clock edge that samples the second of the two half-writes, in either order. The pending marks then clear.
- R8: A single half-write with no write of the other half leaves the active word, and so `out_q`, unchanged.
- R9: A sample accepted on the same edge as the completing write still uses the old word. Samples accepted on later edges use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lo_we | input | 1 | Stage low byte of the correction word |
| cfg_hi_we | input | 1 | Stage high bits of the correction word |
| cfg_data | input | 8 | Configuration write data |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 14 | Signed I sample |
| in_q | input | 14 | Signed Q sample |
| out_valid | output | 1 | Output strobe, two cycles after `in_valid` |
| out_i | output | 14 | Delayed I sample |
| out_q | output | 14 | Corrected, saturated Q sample |

## Verification
The assertions assume that the inputs of the two cycles before a check were driven after reset was released. They count clean cycles since reset and stay silent until two have passed.

They also assume that the correction word changes only through the two write strobes, with no other path into it. The bench keeps `in_valid` and the strobes low while in reset. It drives every input on the falling edge, and it never asserts both strobes in the same cycle.

// File: rtl/iqpc_pkg.sv
package iqpc_pkg;
  // Saturating narrow of a wide signed value to W bits.
  function automatic logic signed [31:0] sat_limit_hi(input int w);
    return (32'sd1 <<< (w - 1)) - 32'sd1;
  endfunction
  function automatic logic signed [31:0] sat_limit_lo(input int w);
    return -(32'sd1 <<< (w - 1));
  endfunction
endpackage

// File: rtl/iqpc_corr_reg.sv
module iqpc_corr_reg #(
  parameter int CFG_W  = 8,
  parameter int CORR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lo_we,
  input  logic                     hi_we,
  input  logic [CFG_W-1:0]         data,
  output logic signed [CORR_W-1:0] corr
);
  localparam int HI_W = CORR_W - CFG_W;

  logic [CFG_W-1:0] lo_stg, lo_nxt;
  logic [HI_W-1:0]  hi_stg, hi_nxt;
  logic             lo_seen, hi_seen, lo_ok, hi_ok;

  always_comb begin
    lo_nxt = lo_we ? data : lo_stg;
    hi_nxt = hi_we ? data[HI_W-1:0] : hi_stg;
    lo_ok  = lo_seen | lo_we;
    hi_ok  = hi_seen | hi_we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stg  <= '0;
      hi_stg  <= '0;
      lo_seen <= 1'b0;
      hi_seen <= 1'b0;
      corr    <= '0;
    end else begin
      lo_stg <= lo_nxt;
      hi_stg <= hi_nxt;
      if (lo_ok && hi_ok) begin
        corr    <= {hi_nxt, lo_nxt};
        lo_seen <= 1'b0;
        hi_seen <= 1'b0;
      end else begin
        lo_seen <= lo_ok;
        hi_seen <= hi_ok;
      end
    end
  end
endmodule

// File: rtl/iqpc_delay.sv
module iqpc_delay #(
  parameter int W     = 14,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= (k == 0) ? d : stg[(k == 0) ? 0 : k-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/iqpc_q_path.sv
module iqpc_q_path
  import iqpc_pkg::*;
#(
  parameter int SAMPLE_W   = 14,
  parameter int CORR_W     = 10,
  parameter int FRAC_SHIFT = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] i_s,
  input  logic signed [SAMPLE_W-1:0] q_s,
  input  logic signed [CORR_W-1:0]   corr,
  output logic signed [SAMPLE_W-1:0] q_out
);
  localparam int PROD_W = SAMPLE_W + CORR_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'(sat_limit_hi(SAMPLE_W));
  localparam logic signed [SUM_W-1:0] MINV = SUM_W'(sat_limit_lo(SAMPLE_W));

  logic signed [PROD_W-1:0]   prod_r;
  logic signed [SAMPLE_W-1:0] q_r;
  logic signed [SUM_W-1:0]    sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_r <= '0;
      q_r    <= '0;
    end else begin
      prod_r <= PROD_W'(i_s) * PROD_W'(corr);
      q_r    <= q_s;
    end
  end

  always_comb begin
    sum = SUM_W'(q_r) + SUM_W'(prod_r >>> FRAC_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst)              q_out <= '0;
    else if (sum > MAXV)  q_out <= MAXV[SAMPLE_W-1:0];
    else if (sum < MINV)  q_out <= MINV[SAMPLE_W-1:0];
    else                  q_out <= sum[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/iq_phase_corrector.sv
module iq_phase_corrector #(
  parameter int SAMPLE_W   = 14,
  parameter int CFG_W      = 8,
  parameter int CORR_W     = 10,
  parameter int FRAC_SHIFT = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_lo_we,
  input  logic                cfg_hi_we,
  input  logic [CFG_W-1:0]    cfg_data,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q
);
  localparam int LAT = 2;

  logic signed [CORR_W-1:0]   corr_active;
  logic signed [SAMPLE_W-1:0] q_corr;

  iqpc_corr_reg #(.CFG_W(CFG_W), .CORR_W(CORR_W)) u_reg (
    .clk(clk), .rst(rst), .lo_we(cfg_lo_we), .hi_we(cfg_hi_we),
    .data(cfg_data), .corr(corr_active)
  );

  iqpc_q_path #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W), .FRAC_SHIFT(FRAC_SHIFT)) u_q (
    .clk(clk), .rst(rst), .i_s($signed(in_i)), .q_s($signed(in_q)),
    .corr(corr_active), .q_out(q_corr)
  );

  iqpc_delay #(.W(SAMPLE_W), .DEPTH(LAT)) u_dly_i (
    .clk(clk), .rst(rst), .d(in_i), .q(out_i)
  );

  iqpc_delay #(.W(1), .DEPTH(LAT)) u_dly_v (
    .clk(clk), .rst(rst), .d(in_valid), .q(out_valid)
  );

  assign out_q = q_corr;
endmodule

// File: rtl/iqpc_chk.sv
module iqpc_chk #(
  parameter int SAMPLE_W = 14,
  parameter int CORR_W   = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_lo_we,
  input logic                cfg_hi_we,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_i,
  input logic [SAMPLE_W-1:0] in_q,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_i,
  input logic [SAMPLE_W-1:0] out_q,
  input logic [CORR_W-1:0]   corr
);
  logic [1:0] clean;
  always_ff @(posedge clk) begin
    if (rst)             clean <= '0;
    else if (clean != 2'd3) clean <= clean + 2'd1;
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (clean >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R2
  i_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (clean >= 2'd2) |-> (out_i == $past(in_i, 2)));

  // R3
  zero_i_q_chk: assert property (@(posedge clk) disable iff (rst)
    (clean >= 2'd2 && $past(in_i, 2) == '0) |-> (out_q == $past(in_q, 2)));

  // R8
  corr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clean >= 2'd1 && !$past(cfg_lo_we || cfg_hi_we)) |-> $stable(corr));
endmodule

bind iq_phase_corrector iqpc_chk #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_lo_we(cfg_lo_we), .cfg_hi_we(cfg_hi_we),
  .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
  .out_i(out_i), .out_q(out_q), .corr(corr_active)
);

// File: tb/tb_iq_phase_corrector.sv
`timescale 1ns/1ps
module tb_iq_phase_corrector;
  localparam int W = 14;
  logic clk = 0, rst = 1;
  logic cfg_lo_we = 0, cfg_hi_we = 0;
  logic [7:0] cfg_data = 0;
  logic in_valid = 0;
  logic [W-1:0] in_i = 0, in_q = 0;
  logic out_valid;
  logic [W-1:0] out_i, out_q;

  always #2.5 clk = ~clk;

  iq_phase_corrector dut (.*);

  int checks = 0, failures = 0;
  string tag = "R1";

  // behavioural model
  int m_corr = 0, m_lo = 0, m_hi = 0;
  bit m_lo_seen = 0, m_hi_seen = 0;
  int s1_v = 0, s1_i = 0, s1_q = 0, s1_c = 0;
  int e_v = 0, e_i = 0, e_q = 0;

  function automatic int sx(input int v, input int w);
    int m = 1 << w;
    v = v & (m - 1);
    return (v >= (m >> 1)) ? v - m : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_corr = 0; m_lo = 0; m_hi = 0; m_lo_seen = 0; m_hi_seen = 0;
      s1_v = 0; s1_i = 0; s1_q = 0; s1_c = 0; e_v = 0; e_i = 0; e_q = 0;
    end else begin
      int s;
      s = s1_q + ((s1_i * s1_c) >>> 11);
      if (s > 8191) s = 8191;
      if (s < -8192) s = -8192;
      e_v = s1_v; e_i = s1_i; e_q = s;
      s1_v = in_valid; s1_i = sx(in_i, W); s1_q = sx(in_q, W); s1_c = m_corr;
      if (cfg_lo_we) begin m_lo = cfg_data; m_lo_seen = 1; end
      if (cfg_hi_we) begin m_hi = cfg_data & 3; m_hi_seen = 1; end
      if (m_lo_seen && m_hi_seen) begin
        m_corr = sx((m_hi << 8) | m_lo, 10);
        m_lo_seen = 0; m_hi_seen = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(rst ? "R1" : "R2", "out_valid", int'(out_valid), e_v);
    chk(rst ? "R1" : "R2", "out_i", sx(out_i, W), e_i);
    chk(rst ? "R1" : tag, "out_q", sx(out_q, W), e_q);
  endtask

  task automatic step(input int iv, input int qv, input bit v);
    @(negedge clk);
    compare();
    in_i = W'(iv); in_q = W'(qv); in_valid = v;
    cfg_lo_we = 0; cfg_hi_we = 0;
  endtask

  task automatic wr(input bit hi, input int d);
    @(negedge clk);
    compare();
    cfg_data = 8'(d); cfg_lo_we = !hi; cfg_hi_we = hi;
    in_i = W'(4000); in_q = W'(-100); in_valid = 1;
  endtask

  task automatic burst(input int n, input int amp);
    for (int k = 0; k < n; k++)
      step(sx($urandom, 16) % amp, sx($urandom, 16) % amp, $urandom % 2);
  endtask

  initial begin
    #20000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) begin @(negedge clk); compare(); end
    rst = 0;
    step(0, 0, 0);
    tag = "R3"; burst(20, 8000);
    // R8: single low write, no commit
    tag = "R8"; wr(0, 8'h40); burst(10, 8000);
    // R7, R9: high write completes (hi then earlier lo), word = 0x040 = 64
    tag = "R9"; wr(1, 8'h00); step(4000, -100, 1); step(4000, -100, 1);
    tag = "R7"; burst(10, 8000);
    // R6: high data with upper bits set, hi first then lo: 0xFE -> bits 10 -> -512
    tag = "R6"; wr(1, 8'hFE); burst(4, 8000); wr(0, 8'h00); burst(10, 8000);
    // R5: saturation both directions
    tag = "R5";
    step(-8192, 8191, 1); step(8191, -8192, 1); step(-8192, -8192, 1); step(8191, 8191, 1);
    burst(3, 100);
    // R4: +511 and other values
    tag = "R4"; wr(0, 8'hFF); wr(1, 8'h01); burst(20, 8192);
    step(8191, 8191, 1); step(-8192, -8192, 1);
    tag = "R4"; wr(1, 8'h03); wr(0, 8'h85); burst(20, 8192);
    tag = "R8"; wr(1, 8'h00); burst(10, 8000);
    tag = "R3"; wr(0, 8'h00); burst(15, 8192);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule